// File: doc/BRIEF.md
# Field Insertion Unit

The field insertion unit merges a bit field taken from one 12-bit word into another 12-bit word. The source word `b_word` is first rotated left by a 4-bit distance, so that any field of it can be moved to any position. A mask is then formed from two bit indices, a low edge `left_idx` and a high edge `right_idx`. Bit positions are numbered 0 (least significant) to 11. Every output position inside the closed range between the two edges takes the rotated source bit. Every position outside that range takes the matching bit of the background word `a_word`.

The datapath is combinational. It is built from a stage-per-distance-bit rotator, a mask generator with one comparator pair per bit, and a merge stage. An output stage follows, and a parameter selects whether it is a register or a plain wire. The default build registers the result, so a result appears one clock after its operands. Distances of 12 to 15 have no meaning for a 12-bit word. For those distances the rotation is suppressed and a flag is raised.

Top module: `fiu_field_insert`

## Requirements
- R1: With the mask covering all bits (`left_idx`=0, `right_idx`=11) and a distance r of 0 to 11, the output is `b_word` rotated left by r, that is out[(i+r) mod 12] = `b_word`[i].
- R2: Output bit i takes the rotated source bit when `left_idx` <= i <= `right_idx`, and takes `a_word`[i] otherwise.
- R3: When `left_idx` > `right_idx`, the output equals `a_word`.
- R4: For distances 12 to 15, `dist_bad` is 1 and the source is not rotated: inside the mask the output carries `b_word` unchanged.
- R5: For distances 0 to 11, `dist_bad` is 0.
- R6: In the registered build (REG_OUT=1), `ins_out` and `dist_bad` reflect the operands present at the previous rising `clk` edge. They hold steady between edges, and stay unchanged while the operands stay unchanged.
- R7: While `rst_n` is low, `ins_out` is 0 and `dist_bad` is 0.
- R8: Index values of 12 to 15 name no bit. A `right_idx` of 12 or more extends the field to bit 11, and a `left_idx` of 12 or more selects no bits, so the output equals `a_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_word | input | 12 | Background word, kept outside the field |
| b_word | input | 12 | Source word, rotated and inserted inside the field |
| rot_dist | input | 4 | Left-rotate distance; legal range 0 to 11 |
| left_idx | input | 4 | Lowest bit position of the field |
| right_idx | input | 4 | Highest bit position of the field |
| ins_out | output | 12 | Merged result |
| dist_bad | output | 1 | Distance was 12 or more |

## Verification
Rotation wrap-around and the field edges meet in the same result. This happens when source bits carried past bit 11 land on bit 0 or 1 while the mask edge lies just beside them. An edge error and a wrap error then show up in the same bit. The bench provokes this by sweeping every legal distance against every pair of edges with random operands. Each result is judged against an independent model of rotate-then-select. A second overlap, an illegal distance together with a partial mask, is judged on both the flag and the unrotated field.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    // Default datapath width of the unit.
    localparam int FIU_WIDTH = 12;

    // Rotate step contributed by distance bit k, reduced modulo the width.
    function automatic int stage_step(input int k, input int width);
        return (1 << k) % width;
    endfunction

endpackage

// File: rtl/fiu_rotator.sv
module fiu_rotator #(
    parameter int WIDTH = fiu_pkg::FIU_WIDTH,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [SEL_W-1:0] amount,
    output logic [WIDTH-1:0] data_out
);

    logic [SEL_W:0][WIDTH-1:0] stage;

    assign stage[0] = data_in;

    // One conditional fixed rotation per distance bit.
    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        localparam int STEP = fiu_pkg::stage_step(k, WIDTH);
        logic [WIDTH-1:0] turned;
        if (STEP == 0) begin : g_identity
            assign turned = stage[k];
        end else begin : g_turn
            assign turned = (stage[k] << STEP) | (stage[k] >> (WIDTH - STEP));
        end
        assign stage[k+1] = amount[k] ? turned : stage[k];
    end

    assign data_out = stage[SEL_W];

endmodule

// File: rtl/fiu_mask_gen.sv
module fiu_mask_gen #(
    parameter int WIDTH = fiu_pkg::FIU_WIDTH,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [IDX_W-1:0] lo_edge,
    input  logic [IDX_W-1:0] hi_edge,
    output logic [WIDTH-1:0] mask
);

    // Each bit compares its own position against both edges.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [IDX_W-1:0] POS = IDX_W'(i);
        assign mask[i] = (lo_edge <= POS) && (POS <= hi_edge);
    end

endmodule

// File: rtl/fiu_out_stage.sv
module fiu_out_stage #(
    parameter int WIDTH   = fiu_pkg::FIU_WIDTH,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] word_d,
    input  logic             flag_d,
    output logic [WIDTH-1:0] word_q,
    output logic             flag_q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                flag_q <= 1'b0;
            end else begin
                word_q <= word_d;
                flag_q <= flag_d;
            end
        end
    end else begin : g_wire
        assign word_q = rst_n ? word_d : '0;
        assign flag_q = rst_n ? flag_d : 1'b0;
    end

endmodule

// File: rtl/fiu_field_insert.sv
module fiu_field_insert #(
    parameter int WIDTH   = fiu_pkg::FIU_WIDTH,
    parameter int SEL_W   = $clog2(WIDTH),
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  logic [SEL_W-1:0] rot_dist,
    input  logic [SEL_W-1:0] left_idx,
    input  logic [SEL_W-1:0] right_idx,
    output logic [WIDTH-1:0] ins_out,
    output logic             dist_bad
);

    localparam logic [SEL_W:0] DIST_LIMIT = (SEL_W+1)'(WIDTH);

    logic             bad_c;
    logic [SEL_W-1:0] dist_eff;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] field_mask;
    logic [WIDTH-1:0] merged;

    // Distances beyond the width are flagged and fall back to no rotation.
    assign bad_c    = {1'b0, rot_dist} >= DIST_LIMIT;
    assign dist_eff = bad_c ? '0 : rot_dist;

    fiu_rotator #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_rot (
        .data_in  (b_word),
        .amount   (dist_eff),
        .data_out (rotated)
    );

    fiu_mask_gen #(.WIDTH(WIDTH), .IDX_W(SEL_W)) u_mask (
        .lo_edge (left_idx),
        .hi_edge (right_idx),
        .mask    (field_mask)
    );

    assign merged = (field_mask & rotated) | (~field_mask & a_word);

    fiu_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_d (merged),
        .flag_d (bad_c),
        .word_q (ins_out),
        .flag_q (dist_bad)
    );

endmodule

// File: rtl/fiu_checker.sv
module fiu_checker #(
    parameter int WIDTH   = 12,
    parameter int SEL_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_word,
    input logic [WIDTH-1:0] b_word,
    input logic [SEL_W-1:0] rot_dist,
    input logic [SEL_W-1:0] left_idx,
    input logic [SEL_W-1:0] right_idx,
    input logic [WIDTH-1:0] ins_out,
    input logic             dist_bad
);

    localparam logic [SEL_W:0]   LIM  = (SEL_W+1)'(WIDTH);
    localparam logic [SEL_W-1:0] TOPI = SEL_W'(WIDTH - 1);

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (ins_out == '0 && !dist_bad));

    if (REG_OUT) begin : g_seq
        assert_empty_keeps_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (left_idx > right_idx) |=> (ins_out == $past(a_word)));

        assert_zero_dist_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (rot_dist == '0 && left_idx == '0 && right_idx == TOPI)
            |=> (ins_out == $past(b_word)));

        assert_flag_follows_dist_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (dist_bad == ({1'b0, $past(rot_dist)} >= LIM)));

        assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(a_word) && $stable(b_word) && $stable(rot_dist)
             && $stable(left_idx) && $stable(right_idx))
            |=> ($stable(ins_out) && $stable(dist_bad)));
    end else begin : g_comb
        assert_empty_keeps_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (left_idx > right_idx) |-> (ins_out == a_word));

        assert_flag_follows_dist_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |-> (dist_bad == ({1'b0, rot_dist} >= LIM)));
    end

endmodule

bind fiu_field_insert fiu_checker #(
    .WIDTH(WIDTH), .SEL_W(SEL_W), .REG_OUT(REG_OUT)
) u_fiu_chk (.*);

// File: tb/test_fiu_field_insert.sv
module test_fiu_field_insert;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] a_word, b_word;
    logic [3:0]  rot_dist, left_idx, right_idx;
    logic [11:0] ins_out;
    logic        dist_bad;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fiu_field_insert i_fiu_field_insert (
        .clk(clk), .rst_n(rst_n), .a_word(a_word), .b_word(b_word),
        .rot_dist(rot_dist), .left_idx(left_idx), .right_idx(right_idx),
        .ins_out(ins_out), .dist_bad(dist_bad)
    );

    // {a, b, dist, left, right, expected out, expected flag}
    localparam logic [48:0] VEC [0:10] = '{
        {12'h000, 12'h001, 4'd5,  4'd0,  4'd11, 12'h020, 1'b0},  // R1
        {12'h000, 12'h801, 4'd1,  4'd0,  4'd11, 12'h003, 1'b0},  // R1 wrap
        {12'h000, 12'hFFF, 4'd3,  4'd4,  4'd7,  12'h0F0, 1'b0},  // R2
        {12'hFFF, 12'h000, 4'd7,  4'd2,  4'd2,  12'hFFB, 1'b0},  // R2 single bit
        {12'h5A5, 12'hFFF, 4'd2,  4'd8,  4'd3,  12'h5A5, 1'b0},  // R3
        {12'hFFF, 12'h123, 4'd0,  4'd0,  4'd11, 12'h123, 1'b0},  // R1
        {12'h000, 12'h001, 4'd11, 4'd0,  4'd11, 12'h800, 1'b0},  // R1 max
        {12'h000, 12'hABC, 4'd4,  4'd0,  4'd11, 12'hBCA, 1'b0},  // R1
        {12'h000, 12'hFFF, 4'd0,  4'd10, 4'd15, 12'hC00, 1'b0},  // R8
        {12'h3C3, 12'hFFF, 4'd0,  4'd12, 4'd15, 12'h3C3, 1'b0},  // R8
        {12'h000, 12'h0F1, 4'd13, 4'd0,  4'd11, 12'h0F1, 1'b1}   // R4
    };

    function automatic logic [11:0] model(input logic [11:0] a, input logic [11:0] b,
                                          input int r, input int l, input int h);
        logic [11:0] rot;
        logic [11:0] res;
        rot = (r >= 12) ? b : 12'((({b, b} << r) >> 12));
        for (int i = 0; i < 12; i++)
            res[i] = (l <= i && i <= h) ? rot[i] : a[i];
        return res;
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [11:0] a, input logic [11:0] b,
                         input logic [3:0] r, input logic [3:0] l, input logic [3:0] h);
        @(negedge clk);
        a_word = a; b_word = b; rot_dist = r; left_idx = l; right_idx = h;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200us;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_word = 12'hFFF; b_word = 12'hFFF; rot_dist = 4'd14; left_idx = 0; right_idx = 11;
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset out", ins_out, 12'h000);
        check("R7 reset flag", {11'b0, dist_bad}, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        foreach (VEC[k]) begin
            apply(VEC[k][48:37], VEC[k][36:25], VEC[k][24:21], VEC[k][20:17], VEC[k][16:13]);
            check("R1/R2/R3/R8 table", ins_out, VEC[k][12:1]);
            check("R4/R5 table flag", {11'b0, dist_bad}, {11'b0, VEC[k][0]});
        end

        // Full sweep of legal distances and edges (R1, R2, R3, R5).
        for (int r = 0; r < 12; r++) begin
            for (int l = 0; l < 12; l++) begin
                for (int h = 0; h < 12; h++) begin
                    logic [11:0] a, b;
                    a = 12'($urandom);
                    b = 12'($urandom);
                    apply(a, b, 4'(r), 4'(l), 4'(h));
                    check("R2 sweep", ins_out, model(a, b, r, l, h));
                    check("R5 sweep flag", {11'b0, dist_bad}, 12'h000);
                end
            end
        end

        // Illegal distances with a partial mask (R4).
        for (int r = 12; r < 16; r++) begin
            apply(12'hA5A, 12'h3C7, 4'(r), 4'd2, 4'd9);
            check("R4 flag", {11'b0, dist_bad}, 12'h001);
            check("R4 unrotated field", ins_out, model(12'hA5A, 12'h3C7, r, 2, 9));
        end

        // Latency: a new operand must not show before the next edge (R6).
        apply(12'h000, 12'h00F, 4'd0, 4'd0, 4'd11);
        @(negedge clk);
        b_word = 12'hF00;
        #1;
        check("R6 held before edge", ins_out, 12'h00F);
        @(posedge clk);
        #1;
        check("R6 updated after edge", ins_out, 12'hF00);

        // Reset in the middle of a run (R7).
        apply(12'hFFF, 12'hFFF, 4'd15, 4'd0, 4'd11);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async clear out", ins_out, 12'h000);
        check("R7 async clear flag", {11'b0, dist_bad}, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule